// File: doc/BRIEF.md
# Low-Power Wait/Stop Clock Sequencer

This block moves a small processor core between three power states: running, waiting and stopped. It produces the enables that gate the CPU clock, the peripheral-timer clock, the free-running counter clock and the oscillator. Instruction decode raises a wait or stop request. A wait request needs a separate indication that the register stacking has finished. The block leaves either low-power state when an unmasked interrupt is pending, or on reset.

While it waits, the block keeps the bus busy with dummy read cycles to the address at which the status register was stacked. It also suppresses RAM writes in every state except running. It decides whether the timer clock may stop during a wait from the interrupt-mask bit together with the watchdog-disable bit. When the core leaves the stopped state, the CPU clock stays off for a fixed settling interval so the oscillator can stabilise. All four clock enables are registered on the falling edge of the source clock. This keeps their changes away from the high phase of the clock they gate.

Top module: `lpm_clkctl`

## Requirements
- R1: Synchronous reset, from any state, puts `pwr_state` at RUN (2'b00). All four clock enables read 1 and `bus_rd_stb` reads 0.
- R2: States are encoded RUN=2'b00, WAIT=2'b01, STOP=2'b10. In RUN, `wait_req` moves to WAIT only when `stack_done` is 1 in the same cycle. Otherwise the state stays RUN.
- R3: In WAIT, `cpu_clk_en` is 0 and `osc_en` is 1.
- R4: In WAIT, `bus_rd_stb` is 1 in every cycle and `bus_addr` holds the value `stack_addr` had on the entry cycle. Outside WAIT, `bus_rd_stb` is 0.
- R5: In WAIT, `tmr_clk_en` is 0 exactly when `i_mask` and `wdog_off` are both 1. Otherwise it is 1.
- R6: In WAIT, `cnt_clk_en` equals `tmr_clk_en` AND `cnt_run`. In RUN it is 1.
- R7: In STOP, all four clock enables are 0. When `stop_req` and `wait_req` come together in RUN, STOP wins.
- R8: STOP and WAIT are left to RUN only when `irq_pend` is 1. Wait and stop requests are ignored in those states.
- R9: On leaving WAIT, `cpu_clk_en` is 1 from the first falling edge after the exit edge.
- R10: On leaving STOP, `cpu_clk_en` stays 0 for SETTLE_CYC cycles and is then 1 (default 4).
- R11: A wait or stop request that arrives in RUN together with `irq_pend`=1 leaves the state at RUN.
- R12: `ram_we_out` equals `ram_we_in` in RUN and is 0 in WAIT and STOP.
- R13: The clock enables change only on the falling edge of `clk`. Just after a rising edge they still show the value from before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | Wait instruction decoded |
| stop_req | input | 1 | Stop instruction decoded |
| stack_done | input | 1 | CPU register stacking has finished |
| irq_pend | input | 1 | An unmasked interrupt (external, non-maskable or internal) is pending |
| i_mask | input | 1 | CPU interrupt-mask bit |
| wdog_off | input | 1 | Watchdog disabled by configuration |
| cnt_run | input | 1 | Counter clock enable bit |
| stack_addr | input | AW | Address where the status register was stacked |
| ram_we_in | input | 1 | RAM write enable from the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Peripheral-timer clock enable |
| cnt_clk_en | output | 1 | Free-running counter clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_rd_stb | output | 1 | Dummy read cycle strobe during WAIT |
| bus_addr | output | AW | Address of the dummy read |
| ram_we_out | output | 1 | Gated RAM write enable |
| pwr_state | output | 2 | Current power state |

## Verification
A low-power request and an unmasked interrupt can reach the sequencer in the same cycle. The bench provokes this by asserting `wait_req` with `stack_done`, and separately `stop_req`, together with `irq_pend`. It judges the result by checking that `pwr_state` stays RUN and that every clock enable stays 1. The two requests can also arrive together. Driving `wait_req` and `stop_req` in one cycle must give STOP with every enable at 0.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'b00,
        PS_WAIT = 2'b01,
        PS_STOP = 2'b10
    } pstate_t;

    typedef struct packed {
        logic cpu;
        logic tmr;
        logic cnt;
        logic osc;
    } clken_t;

    localparam clken_t CLKEN_ALL = '{cpu: 1'b1, tmr: 1'b1, cnt: 1'b1, osc: 1'b1};
    localparam clken_t CLKEN_OFF = '{cpu: 1'b0, tmr: 1'b0, cnt: 1'b0, osc: 1'b0};

    // Decide the clock enables for one state and the gating inputs.
    function automatic clken_t clk_plan(pstate_t s, logic settling, logic imask,
                                        logic wdog_off, logic cnt_run);
        clken_t e;
        e = CLKEN_OFF;
        case (s)
            PS_RUN: begin
                e     = CLKEN_ALL;
                e.cpu = ~settling;
            end
            PS_WAIT: begin
                e.cpu = 1'b0;
                e.osc = 1'b1;
                e.tmr = ~(imask & wdog_off);
                e.cnt = e.tmr & cnt_run;
            end
            default: e = CLKEN_OFF;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wait_req,
    input  logic    stop_req,
    input  logic    stack_done,
    input  logic    irq_pend,
    output pstate_t state,
    output pstate_t nxt,
    output logic    settling
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic [SW-1:0] settle_q;

    always_comb begin
        nxt = state;
        case (state)
            PS_RUN: begin
                if (irq_pend)                    nxt = PS_RUN;
                else if (stop_req)               nxt = PS_STOP;
                else if (wait_req && stack_done) nxt = PS_WAIT;
            end
            PS_WAIT: if (irq_pend) nxt = PS_RUN;
            PS_STOP: if (irq_pend) nxt = PS_RUN;
            default: nxt = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_RUN;
            settle_q <= '0;
        end else begin
            state <= nxt;
            if (state == PS_STOP && nxt == PS_RUN)
                settle_q <= SW'(SETTLE_CYC);
            else if (nxt == PS_STOP)
                settle_q <= '0;
            else if (settle_q != '0)
                settle_q <= settle_q - SW'(1);
        end
    end

    assign settling = (settle_q != '0);

endmodule

// File: rtl/lpm_busrd.sv
module lpm_busrd
    import lpm_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pstate_t       state,
    input  pstate_t       nxt,
    input  logic [AW-1:0] stack_addr,
    output logic          rd_stb,
    output logic [AW-1:0] rd_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_stb  <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_stb <= (nxt == PS_WAIT);
            if (state != PS_WAIT && nxt == PS_WAIT)
                rd_addr <= stack_addr;
            else if (nxt != PS_WAIT)
                rd_addr <= '0;
        end
    end

endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
    import lpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_t state,
    input  logic    settling,
    input  logic    i_mask,
    input  logic    wdog_off,
    input  logic    cnt_run,
    output clken_t  en
);
    // Registered on the falling edge so enables settle while the clock is low.
    always_ff @(negedge clk) begin
        if (rst) en <= CLKEN_ALL;
        else     en <= clk_plan(state, settling, i_mask, wdog_off, cnt_run);
    end

endmodule

// File: rtl/lpm_clkctl.sv
module lpm_clkctl
    import lpm_pkg::*;
#(
    parameter int AW         = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wait_req,
    input  logic          stop_req,
    input  logic          stack_done,
    input  logic          irq_pend,
    input  logic          i_mask,
    input  logic          wdog_off,
    input  logic          cnt_run,
    input  logic [AW-1:0] stack_addr,
    input  logic          ram_we_in,
    output logic          cpu_clk_en,
    output logic          tmr_clk_en,
    output logic          cnt_clk_en,
    output logic          osc_en,
    output logic          bus_rd_stb,
    output logic [AW-1:0] bus_addr,
    output logic          ram_we_out,
    output logic [1:0]    pwr_state
);
    pstate_t state, nxt;
    logic    settling;
    clken_t  en;

    lpm_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
        .stack_done(stack_done), .irq_pend(irq_pend),
        .state(state), .nxt(nxt), .settling(settling)
    );

    lpm_busrd #(.AW(AW)) u_busrd (
        .clk(clk), .rst(rst), .state(state), .nxt(nxt),
        .stack_addr(stack_addr), .rd_stb(bus_rd_stb), .rd_addr(bus_addr)
    );

    lpm_gate u_gate (
        .clk(clk), .rst(rst), .state(state), .settling(settling),
        .i_mask(i_mask), .wdog_off(wdog_off), .cnt_run(cnt_run), .en(en)
    );

    assign cpu_clk_en = en.cpu;
    assign tmr_clk_en = en.tmr;
    assign cnt_clk_en = en.cnt;
    assign osc_en     = en.osc;
    assign ram_we_out = ram_we_in & (state == PS_RUN);
    assign pwr_state  = state;

endmodule

// File: rtl/lpm_clkctl_chk.sv
module lpm_clkctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wait_req,
    input logic       stop_req,
    input logic       irq_pend,
    input logic       i_mask,
    input logic       wdog_off,
    input logic       cpu_clk_en,
    input logic       tmr_clk_en,
    input logic       cnt_clk_en,
    input logic       osc_en,
    input logic       bus_rd_stb,
    input logic       ram_we_out,
    input logic [1:0] pwr_state
);
    a_r2_legal_state: assert property (@(posedge clk) disable iff (rst)
        pwr_state != 2'b11);

    a_r3_wait_clocks: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b01 |-> !cpu_clk_en && osc_en);

    a_r4_wait_reads: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b01 |-> bus_rd_stb);

    a_r4_no_reads_outside: assert property (@(posedge clk) disable iff (rst)
        pwr_state != 2'b01 |-> !bus_rd_stb);

    a_r7_stop_dark: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b10 |-> !cpu_clk_en && !tmr_clk_en && !cnt_clk_en && !osc_en);

    a_r8_wait_exit: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b01 && irq_pend |=> pwr_state == 2'b00);

    a_r8_stop_hold: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b10 && !irq_pend |=> pwr_state == 2'b10);

    a_r11_irq_keeps_run: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b00 && irq_pend && (wait_req || stop_req) |=> pwr_state == 2'b00);

    a_r12_ram_guard: assert property (@(posedge clk) disable iff (rst)
        ram_we_out |-> pwr_state == 2'b00);

    a_r5_timer_gate: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 2'b01 && $stable(pwr_state) && $stable(i_mask) && $stable(wdog_off)
        |-> tmr_clk_en == !(i_mask && wdog_off));

endmodule

bind lpm_clkctl lpm_clkctl_chk u_chk (
    .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .i_mask(i_mask), .wdog_off(wdog_off),
    .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .cnt_clk_en(cnt_clk_en),
    .osc_en(osc_en), .bus_rd_stb(bus_rd_stb), .ram_we_out(ram_we_out),
    .pwr_state(pwr_state)
);

// File: tb/lpm_clkctl_test.sv
module lpm_clkctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int AW         = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_req = 0, stop_req = 0, stack_done = 0, irq_pend = 0;
    logic i_mask = 0, wdog_off = 0, cnt_run = 0, ram_we_in = 0;
    logic [AW-1:0] stack_addr = '0;
    logic cpu_clk_en, tmr_clk_en, cnt_clk_en, osc_en, bus_rd_stb, ram_we_out;
    logic [AW-1:0] bus_addr;
    logic [1:0] pwr_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_clkctl #(.AW(AW), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
        .stack_done(stack_done), .irq_pend(irq_pend), .i_mask(i_mask),
        .wdog_off(wdog_off), .cnt_run(cnt_run), .stack_addr(stack_addr),
        .ram_we_in(ram_we_in), .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en),
        .cnt_clk_en(cnt_clk_en), .osc_en(osc_en), .bus_rd_stb(bus_rd_stb),
        .bus_addr(bus_addr), .ram_we_out(ram_we_out), .pwr_state(pwr_state)
    );

    // inputs {wait,stop,stack,irq,imask,wdog,cnt} | expected {state[1:0],cpu,tmr,cnt,osc,rd}
    localparam int NV = 9;
    localparam logic [13:0] VEC [NV] = '{
        14'b0000000_00_11110, // R1 idle run
        14'b1000000_00_11110, // R2 wait without stacking done
        14'b1011000_00_11110, // R11 wait with pending irq
        14'b1010001_01_01111, // R2 R3 enter wait, timer and counter run
        14'b0000111_01_00011, // R5 mask and watchdog off stop timer
        14'b0000100_01_01011, // R6 counter bit clear
        14'b0001000_00_11110, // R8 R9 irq leaves wait
        14'b0100000_10_00000, // R7 enter stop
        14'b1010000_10_00000  // R8 wait request ignored in stop
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic clr_in();
        wait_req = 0; stop_req = 0; stack_done = 0; irq_pend = 0;
    endtask

    function automatic logic [6:0] outs();
        return {pwr_state, cpu_clk_en, tmr_clk_en, cnt_clk_en, osc_en, bus_rd_stb};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        chk("R1 reset outputs", 32'(outs()), 32'b00_11110);

        for (int i = 0; i < NV; i++) begin
            {wait_req, stop_req, stack_done, irq_pend, i_mask, wdog_off, cnt_run} = VEC[i][13:7];
            step();
            chk($sformatf("vector %0d (R2-table)", i), 32'(outs()), 32'(VEC[i][6:0]));
        end

        // R10: leave STOP, CPU clock held for the settling interval
        clr_in(); i_mask = 0; wdog_off = 0; cnt_run = 0;
        irq_pend = 1;
        step();
        chk("R10 exit state", 32'(pwr_state), 0);
        chk("R10 cpu held at exit", 32'(cpu_clk_en), 0);
        chk("R10 osc on at exit", 32'(osc_en), 1);
        irq_pend = 0;
        for (int k = 1; k < SETTLE; k++) begin
            step();
            chk($sformatf("R10 cpu held %0d", k), 32'(cpu_clk_en), 0);
        end
        step();
        chk("R10 cpu released", 32'(cpu_clk_en), 1);

        // R7: wait and stop together, stop wins
        wait_req = 1; stop_req = 1; stack_done = 1;
        step();
        chk("R7 stop priority", 32'(outs()), 32'b10_00000);
        clr_in(); irq_pend = 1;
        step();
        irq_pend = 0;
        repeat (SETTLE) step();

        // R11: stop with pending irq stays in run
        stop_req = 1; irq_pend = 1;
        step();
        chk("R11 stop with irq", 32'(outs()), 32'b00_11110);
        clr_in();

        // R13 and R4: enter wait, enables move only at the falling edge
        stack_addr = 16'h01F3;
        wait_req = 1; stack_done = 1;
        @(posedge clk); #1;
        chk("R13 cpu still on after rising edge", 32'(cpu_clk_en), 1);
        chk("R2 state already wait", 32'(pwr_state), 1);
        @(negedge clk); #1;
        chk("R13 cpu off after falling edge", 32'(cpu_clk_en), 0);
        chk("R4 read address", 32'(bus_addr), 32'h01F3);
        wait_req = 0; stack_done = 0;
        stack_addr = 16'hBEEF;
        ram_we_in = 1;
        step();
        chk("R4 address held", 32'(bus_addr), 32'h01F3);
        chk("R4 read strobe repeats", 32'(bus_rd_stb), 1);
        chk("R12 ram write blocked in wait", 32'(ram_we_out), 0);
        stop_req = 1;
        step();
        chk("R8 stop ignored in wait", 32'(pwr_state), 1);
        stop_req = 0;

        // R1: reset from wait
        rst = 1;
        step();
        rst = 0;
        chk("R1 reset from wait", 32'(outs()), 32'b00_11110);
        #1;
        chk("R12 ram write passes in run", 32'(ram_we_out), 1);
        stop_req = 1;
        step();
        stop_req = 0;
        #1;
        chk("R12 ram write blocked in stop", 32'(ram_we_out), 0);
        ram_we_in = 0;
        rst = 1;
        step();
        rst = 0;
        chk("R1 reset from stop", 32'(outs()), 32'b00_11110);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule